// File: doc/BRIEF.md
# Shifted-Operand Recomputation Checker

This block wraps a small combinational ALU that can add, subtract, AND, OR and XOR. It checks the ALU for faults by computing each operation twice. The first pass runs on the plain operands, and its result is kept in a holding register. The second pass moves both operands up by K bit positions and runs the same ALU again. It then moves the result back down by K and compares it with the held value. A fault that corrupts a fixed slice of ALU output bits lands on different result bits in the two passes, so the two answers disagree.

When the passes disagree, the operation is retried once from the first pass. If the retry still disagrees, the operation ends with the error flag raised. Operands enter through a valid/ready handshake. The result comes back with a one-cycle done pulse and an error flag. A test-only mask port XORs into the ALU output in both passes, which lets a bench model a damaged bit slice. The ALU is W+K bits wide, so neither the shifted operands nor the carries are lost.

Top module: `shift_recompute_chk`

## Requirements
- R1: While reset is held and in the cycle after it, `in_ready` is 1 and `res_done`, `res_error` and `res_data` are 0.
- R2: The opcode selects the operation: 0 add, 1 subtract, 2 AND, 3 OR, 4 XOR, and 5 to 7 give a zero result. Add and subtract treat the operands as unsigned and wrap modulo 2^W.
- R3: An operation is accepted on a rising edge where `in_valid` and `in_ready` are both 1. `in_ready` is 0 from that edge until the operation completes.
- R4: With an all-zero fault mask, `res_done` is high for exactly one cycle, starting at the second rising edge after the accepting edge. `res_data` then holds the R2 result and `res_error` is 0.
- R5: The fault mask can hold 1 to K-1 adjacent ones at any position within the W+K ALU output bits. If such a mask is held for the whole operation, `res_error` is 1 with `res_done`, starting at the fourth rising edge after the accepting edge. `res_data` then carries the low W bits of the true result XOR the mask.
- R6: Only one retry is made. The mask may be nonzero during the first attempt and zero from the third rising edge after acceptance onward. In that case the retry succeeds: `res_error` is 0, `res_data` is the true result, and `res_done` starts at the fourth rising edge after acceptance.
- R7: `res_data` and `res_error` change only on the edge that raises `res_done`. They hold their values until the next completion.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Operands and opcode are valid |
| in_ready | output | 1 | Block is idle and accepts an operation |
| in_op | input | 3 | Operation code (R2) |
| in_a | input | W | First operand |
| in_b | input | W | Second operand |
| fault_mask | input | W+K | Test-only XOR mask on the ALU output, applied in both passes |
| res_data | output | W | Result of the last completed operation |
| res_done | output | 1 | One-cycle completion pulse |
| res_error | output | 1 | Last operation failed its retry |

## Verification
The hardest case to reach is a fault that disappears between the failed first attempt and the retry. Reaching it means changing the mask port in a window only two cycles wide. The bench drives a mask with the operation, waits for the mismatch edge, and clears the mask at the falling edge before the retry's first pass. It then expects a clean result one retry later. Every slice of one and two adjacent bits across the whole ALU width is also held as a permanent fault, and each must end in an error.

// File: rtl/rcc_pkg.sv
// Package: shared opcode and sequencing types of the recomputation checker.
// Assumes: opcodes are 3 bits wide; the codes left unused give a zero result.
package rcc_pkg;

    typedef enum logic [2:0] {
        OP_ADD = 3'd0,
        OP_SUB = 3'd1,
        OP_AND = 3'd2,
        OP_OR  = 3'd3,
        OP_XOR = 3'd4
    } alu_op_e;

    typedef enum logic [1:0] {
        PH_IDLE   = 2'd0,
        PH_FIRST  = 2'd1,
        PH_SECOND = 2'd2,
        PH_FINISH = 2'd3
    } phase_e;

endpackage

// File: rtl/rcc_alu.sv
// Module: rcc_alu
// A trivial combinational ALU, DW bits wide. A test-only XOR mask is applied
// to its output to model a faulty bit slice.
// Assumes: operands arrive already widened to DW; the result wraps modulo 2^DW.
module rcc_alu
    import rcc_pkg::*;
#(
    parameter int DW = 19
) (
    input  logic [DW-1:0] opa,
    input  logic [DW-1:0] opb,
    input  logic [2:0]    op,
    input  logic [DW-1:0] fault_xor,
    output logic [DW-1:0] y
);

    logic [DW-1:0] raw;

    // Select the operation result.
    always_comb begin
        case (alu_op_e'(op))
            OP_ADD:  raw = opa + opb;
            OP_SUB:  raw = opa - opb;
            OP_AND:  raw = opa & opb;
            OP_OR:   raw = opa | opb;
            OP_XOR:  raw = opa ^ opb;
            default: raw = '0;
        endcase
    end

    // Corrupt the output with the injected fault pattern.
    assign y = raw ^ fault_xor;

endmodule

// File: rtl/rcc_shift.sv
// Module: rcc_shift
// A fixed shifter by SH positions. With TO_HIGH set it widens the input to OW
// bits and moves it up (encode). Otherwise it moves the input down and keeps
// the low OW bits (decode).
// Assumes: for encode OW >= IW + SH; for decode IW >= OW + SH.
module rcc_shift #(
    parameter int IW      = 16,
    parameter int OW      = 19,
    parameter int SH      = 3,
    parameter bit TO_HIGH = 1'b1
) (
    input  logic [IW-1:0] din,
    output logic [OW-1:0] dout
);

    generate
        if (TO_HIGH) begin : g_up
            // Encode: zero-extend, then shift toward the MSB.
            assign dout = OW'(din) << SH;
        end else begin : g_down
            // Decode: logical shift toward the LSB, keep the low OW bits.
            assign dout = OW'(din >> SH);
        end
    endgenerate

endmodule

// File: rtl/rcc_ctrl.sv
// Module: rcc_ctrl
// Sequencer: idle -> plain pass -> shifted pass -> finish. A mismatch on the
// shifted pass sends it back to the plain pass once. A second mismatch
// finishes the operation with an error.
// Assumes: mismatch is valid during the shifted pass only.
module rcc_ctrl
    import rcc_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic in_valid,
    input  logic mismatch,
    output logic in_ready,
    output logic take,
    output logic pass_plain,
    output logic pass_shift,
    output logic finish,
    output logic finish_err,
    output logic done
);

    phase_e phase;
    logic   retried;

    assign in_ready   = (phase == PH_IDLE);
    assign take       = in_valid && in_ready;
    assign pass_plain = (phase == PH_FIRST);
    assign pass_shift = (phase == PH_SECOND);
    assign finish     = pass_shift && (!mismatch || retried);
    assign finish_err = pass_shift && mismatch && retried;
    assign done       = (phase == PH_FINISH);

    // Advance the phase and track whether the retry has been used.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase   <= PH_IDLE;
            retried <= 1'b0;
        end else begin
            case (phase)
                PH_IDLE: begin
                    if (take) begin
                        phase   <= PH_FIRST;
                        retried <= 1'b0;
                    end
                end
                PH_FIRST:  phase <= PH_SECOND;
                PH_SECOND: begin
                    if (mismatch && !retried) begin
                        phase   <= PH_FIRST;
                        retried <= 1'b1;
                    end else begin
                        phase <= PH_FINISH;
                    end
                end
                default:   phase <= PH_IDLE;
            endcase
        end
    end

    // R3
    accept_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready) |=> !in_ready);

    // R4
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R4
    clean_finish_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pass_shift && !mismatch) |=> done);

    // R6
    retry_once_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pass_shift && mismatch && !retried) |=> (pass_plain && !done));

    // R5
    second_miss_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pass_shift && mismatch && retried) |=> done);

endmodule

// File: rtl/shift_recompute_chk.sv
// Module: shift_recompute_chk
// Time-redundant fault checker around a combinational ALU. The plain pass
// result is saved. The shifted pass result is decoded and compared with it.
// One retry is made on a mismatch; a second mismatch raises res_error.
// Assumes: single-cycle ALU; fault_mask is for test use only and is held at
// zero in the field.
module shift_recompute_chk #(
    parameter int W = 16,
    parameter int K = 3
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           in_valid,
    output logic           in_ready,
    input  logic [2:0]     in_op,
    input  logic [W-1:0]   in_a,
    input  logic [W-1:0]   in_b,
    input  logic [W+K-1:0] fault_mask,
    output logic [W-1:0]   res_data,
    output logic           res_done,
    output logic           res_error
);

    localparam int AW = W + K;

    logic [W-1:0]  opa_q, opb_q, saved_q;
    logic [2:0]    op_q;
    logic [AW-1:0] enc_a, enc_b, alu_a, alu_b, alu_y;
    logic [W-1:0]  dec_y;
    logic          mismatch, take, pass_plain, pass_shift, finish, finish_err;

    rcc_ctrl u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .in_valid   (in_valid),
        .mismatch   (mismatch),
        .in_ready   (in_ready),
        .take       (take),
        .pass_plain (pass_plain),
        .pass_shift (pass_shift),
        .finish     (finish),
        .finish_err (finish_err),
        .done       (res_done)
    );

    rcc_shift #(.IW(W), .OW(AW), .SH(K), .TO_HIGH(1'b1)) u_enc_a (
        .din (opa_q), .dout (enc_a)
    );

    rcc_shift #(.IW(W), .OW(AW), .SH(K), .TO_HIGH(1'b1)) u_enc_b (
        .din (opb_q), .dout (enc_b)
    );

    // Feed plain zero-extended operands in the first pass, encoded in the second.
    always_comb begin
        if (pass_shift) begin
            alu_a = enc_a;
            alu_b = enc_b;
        end else begin
            alu_a = {{K{1'b0}}, opa_q};
            alu_b = {{K{1'b0}}, opb_q};
        end
    end

    rcc_alu #(.DW(AW)) u_alu (
        .opa       (alu_a),
        .opb       (alu_b),
        .op        (op_q),
        .fault_xor (fault_mask),
        .y         (alu_y)
    );

    rcc_shift #(.IW(AW), .OW(W), .SH(K), .TO_HIGH(1'b0)) u_dec (
        .din (alu_y), .dout (dec_y)
    );

    // Comparator between the decoded shifted result and the saved plain result.
    assign mismatch = (dec_y != saved_q);

    // Capture the operands on acceptance.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            opa_q <= '0;
            opb_q <= '0;
            op_q  <= '0;
        end else if (take) begin
            opa_q <= in_a;
            opb_q <= in_b;
            op_q  <= in_op;
        end
    end

    // Store the plain-pass result for comparison.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            saved_q <= '0;
        end else if (pass_plain) begin
            saved_q <= alu_y[W-1:0];
        end
    end

    // Publish result and error flag when the operation finishes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            res_data  <= '0;
            res_error <= 1'b0;
        end else if (finish) begin
            res_data  <= saved_q;
            res_error <= finish_err;
        end
    end

    // R7
    data_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(res_data) |-> res_done);

    // R7
    error_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(res_error) |-> res_done);

    // R5
    error_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        finish_err |=> (res_done && res_error));

    // R4
    clean_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (finish && !finish_err) |=> !res_error);

endmodule

// File: tb/shift_recompute_chk_tb.sv
`timescale 1ns/1ps
module shift_recompute_chk_tb;

    localparam int W  = 16;
    localparam int K  = 3;
    localparam int AW = W + K;

    typedef struct {
        logic [W-1:0] data;
        logic         err;
        int           cyc;
        string        req;
    } exp_t;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic           in_valid = 1'b0;
    logic           in_ready;
    logic [2:0]     in_op = '0;
    logic [W-1:0]   in_a = '0;
    logic [W-1:0]   in_b = '0;
    logic [AW-1:0]  fault_mask = '0;
    logic [W-1:0]   res_data;
    logic           res_done;
    logic           res_error;

    int   checks = 0;
    int   errors = 0;
    int   cyc = 0;
    exp_t sb[$];

    always #4 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    shift_recompute_chk #(.W(W), .K(K)) u_dut (
        .clk (clk), .rst_n (rst_n), .in_valid (in_valid), .in_ready (in_ready),
        .in_op (in_op), .in_a (in_a), .in_b (in_b), .fault_mask (fault_mask),
        .res_data (res_data), .res_done (res_done), .res_error (res_error)
    );

    function automatic logic [W-1:0] ref_op(input logic [2:0] op,
                                            input logic [W-1:0] a,
                                            input logic [W-1:0] b);
        case (op)
            3'd0:    return a + b;
            3'd1:    return a - b;
            3'd2:    return a & b;
            3'd3:    return a | b;
            3'd4:    return a ^ b;
            default: return '0;
        endcase
    endfunction

    task automatic check(input string req, input logic [31:0] act,
                         input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // Driver: issue one operation and push its expected outcome.
    // mode 0: no fault, 1: permanent mask, 2: mask only during first attempt.
    task automatic issue(input logic [2:0] op, input logic [W-1:0] a,
                         input logic [W-1:0] b, input logic [AW-1:0] m,
                         input int mode, input string req);
        exp_t e;
        logic [W-1:0] r;
        @(negedge clk);
        while (!in_ready) @(negedge clk);
        in_op = op; in_a = a; in_b = b; fault_mask = m; in_valid = 1'b1;
        @(posedge clk);
        @(negedge clk);
        in_valid = 1'b0;
        check("R3 busy after accept", {31'd0, in_ready}, 32'd0);
        r = ref_op(op, a, b);
        e.data = (mode == 1) ? (r ^ m[W-1:0]) : r;
        e.err  = (mode == 1);
        e.cyc  = cyc + ((mode == 0) ? 2 : 4);
        e.req  = req;
        sb.push_back(e);
        if (mode == 2) begin
            @(posedge clk);
            @(posedge clk);
            @(negedge clk);
            fault_mask = '0;
        end
        while (!in_ready) @(negedge clk);
        fault_mask = '0;
    endtask

    // Monitor: pop and compare on every completion pulse.
    always @(negedge clk) begin
        if (rst_n && res_done) begin
            if (sb.size() == 0) begin
                checks++; errors++;
                $display("FAIL R4 unexpected done: actual 1 expected 0");
            end else begin
                exp_t e;
                e = sb.pop_front();
                check({e.req, " data"}, {16'd0, res_data}, {16'd0, e.data});
                check({e.req, " error"}, {31'd0, res_error}, {31'd0, e.err});
                check({e.req, " latency"}, cyc, e.cyc);
            end
        end
    end

    // Watchdog.
    initial begin
        #1_000_000;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        logic [W-1:0] hold_d;
        logic         hold_e;
        repeat (3) @(posedge clk);
        @(negedge clk);
        check("R1 ready", {31'd0, in_ready}, 32'd1);
        check("R1 done", {31'd0, res_done}, 32'd0);
        check("R1 error", {31'd0, res_error}, 32'd0);
        check("R1 data", {16'd0, res_data}, 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 ready after release", {31'd0, in_ready}, 32'd1);

        // R2 / R4 directed operations including wrap cases.
        issue(3'd0, 16'h1234, 16'h0F0F, '0, 0, "R2 add");
        issue(3'd0, 16'hFFFF, 16'h0001, '0, 0, "R2 add wrap");
        issue(3'd1, 16'h0000, 16'h0001, '0, 0, "R2 sub borrow");
        issue(3'd1, 16'h0005, 16'h0003, '0, 0, "R2 sub");
        issue(3'd2, 16'hF0F0, 16'h3C3C, '0, 0, "R2 and");
        issue(3'd3, 16'hF000, 16'h000F, '0, 0, "R2 or");
        issue(3'd4, 16'hAAAA, 16'hFFFF, '0, 0, "R2 xor");
        issue(3'd5, 16'h1111, 16'h2222, '0, 0, "R2 code5 zero");
        issue(3'd7, 16'hFFFF, 16'hFFFF, '0, 0, "R2 code7 zero");

        // R4 random fault-free operations.
        for (int i = 0; i < 24; i++)
            issue(3'($urandom_range(0, 7)), 16'($urandom), 16'($urandom),
                  '0, 0, "R4 random");

        // R7: outputs hold while idle and while a new operation runs.
        repeat (3) @(negedge clk);
        hold_d = res_data;
        hold_e = res_error;
        in_op = 3'd0; in_a = 16'h0101; in_b = 16'h0202; in_valid = 1'b1;
        @(posedge clk);
        @(negedge clk);
        in_valid = 1'b0;
        check("R7 data held during run", {16'd0, res_data}, {16'd0, hold_d});
        check("R7 error held during run", {31'd0, res_error}, {31'd0, hold_e});
        begin
            exp_t e;
            e.data = 16'h0303; e.err = 1'b0; e.cyc = cyc + 2; e.req = "R7 op";
            sb.push_back(e);
        end
        while (!in_ready) @(negedge clk);

        // R5: every slice of 1..K-1 adjacent bits, held permanently.
        for (int l = 1; l < K; l++)
            for (int p = 0; p <= AW - l; p++)
                issue(3'($urandom_range(0, 4)), 16'($urandom), 16'($urandom),
                      AW'(((1 << l) - 1) << p), 1, "R5 stuck slice");

        // R7: error flag persists until next completion.
        repeat (2) @(negedge clk);
        check("R7 error persists", {31'd0, res_error}, 32'd1);

        // R6: faults present only during the first attempt.
        issue(3'd0, 16'h7FFF, 16'h0001, AW'(19'h00003), 2, "R6 transient low");
        issue(3'd1, 16'h1000, 16'h2000, AW'(19'h00180), 2, "R6 transient mid");
        issue(3'd4, 16'h5A5A, 16'h0F0F, AW'(19'h08000), 2, "R6 transient top");
        issue(3'd3, 16'h0000, 16'h0000, AW'(19'h60000), 2, "R6 transient ext");

        repeat (6) @(negedge clk);
        check("R4 all results delivered", sb.size(), 32'd0);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule